// File: doc/BRIEF.md
# Per-Source Trigger Interrupt Controller

This block gathers 32 interrupt inputs and presents them to a processor as two request lines and one wake line. Each input is synchronized to the controller clock. Firmware then gives it a trigger type, an enable bit, a wake-enable bit, a route that selects one of the two request lines, and a source-select attribute. Every control register is updated through a write-one-to-set address and a write-one-to-clear address. As a result, firmware can change one source without reading the register first.

Edge-type sources are latched into rise and fall capture registers. Firmware acknowledges them by writing ones to a dedicated clear address for each capture register. Level-type sources are not latched: their pending state follows the synchronized input. Two read-only status words show, for each request line, which enabled and routed sources are requesting at that moment. The bus port is a single synchronous write strobe with a combinational read.

Top module: `trig_intc`

## Requirements
- R1: After reset, every readable word reads zero, and `req0_o`, `req1_o` and `wake_o` are low.
- R2: The control words are trigger bit 0 (0x00), trigger bit 1 (0x08), trigger bit 2 (0x10), route (0x18), source-select (0x20), enable (0x28) and wake-enable (0x30). A write to the base address sets the bits that are 1 in the data. A write to base+4 clears the bits that are 1 in the data. Bits that are 0 in the data are unchanged. A read at either address returns the current value.
- R3: A source's trigger code is {bit 2, bit 1, bit 0}. The codes are 001 rising edge, 010 falling edge, 101 high level and 110 low level. Every other code, 000 included, disables the source, and a disabled source never requests.
- R4: A level source's status follows its input two clock edges after the input changes. In low-level mode the status is the inverse of the input.
- R5: Rise and fall captures are readable at 0x38 and 0x40. A capture bit sets on the third clock edge after the input transition, and it sets even while the source is disabled by its enable bit. It holds until a 1 is written to the matching bit at 0x3C (rise) or 0x44 (fall).
- R6: A requesting source with route bit 1 appears in status word 0 (0x48) and drives `req0_o`. A requesting source with route bit 0 appears in status word 1 (0x4C) and drives `req1_o`.
- R7: A source with enable bit 0 appears in neither status word and drives no request line.
- R8: `wake_o` is high exactly when a requesting source has its wake-enable bit set, whatever its enable bit is.
- R9: The source-select word is stored and read back, and it has no effect on status, requests or wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_i | input | 32 | Raw interrupt inputs, asynchronous |
| bus_addr | input | 8 | Byte address for a read or write |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| req0_o | output | 1 | Request line 0 |
| req1_o | output | 1 | Request line 1 |
| wake_o | output | 1 | Wake line |

## Verification
A wrong bit in a control word shows on the cycle after the write, either when the word is read back or when a request line changes. A bad synchronizer or edge path shows as a status or capture bit that appears one edge early or late, so the bench samples both the cycle before and the cycle after the expected edge. A capture bit that fails to clear, or that misses an event while the source is disabled, keeps or loses a request as soon as the enable bit is set.

// File: rtl/trig_intc_pkg.sv
package trig_intc_pkg;

  localparam int NUM_CTL = 7;

  // word index = byte address / 8 ; byte address bit 2 selects set/clear alias
  localparam int IDX_CFG0  = 0;
  localparam int IDX_CFG1  = 1;
  localparam int IDX_CFG2  = 2;
  localparam int IDX_ROUTE = 3;
  localparam int IDX_SSEL  = 4;
  localparam int IDX_EN    = 5;
  localparam int IDX_WAKE  = 6;
  localparam int IDX_RISE  = 7;
  localparam int IDX_FALL  = 8;
  localparam int IDX_STAT  = 9;

  typedef enum logic [2:0] {
    TRIG_OFF  = 3'b000,
    TRIG_RISE = 3'b001,
    TRIG_FALL = 3'b010,
    TRIG_HIGH = 3'b101,
    TRIG_LOW  = 3'b110
  } trig_e;

  function automatic logic src_pending(input logic [2:0] code, input logic lvl,
                                       input logic rise_cap, input logic fall_cap);
    case (code)
      TRIG_RISE: src_pending = rise_cap;
      TRIG_FALL: src_pending = fall_cap;
      TRIG_HIGH: src_pending = lvl;
      TRIG_LOW:  src_pending = ~lvl;
      default:   src_pending = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/trig_intc_sync.sv
module trig_intc_sync #(
  parameter int NSRC   = 32,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] raw_i,
  output logic [NSRC-1:0] lvl_o,
  output logic [NSRC-1:0] prev_o
);
  logic [STAGES-1:0][NSRC-1:0] stg_q;
  logic [NSRC-1:0]             prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q[0] <= '0;
    else        stg_q[0] <= raw_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= '0;
      else        stg_q[s] <= stg_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= stg_q[STAGES-1];
  end

  assign lvl_o  = stg_q[STAGES-1];
  assign prev_o = prev_q;
endmodule

// File: rtl/trig_intc_detect.sv
module trig_intc_detect
  import trig_intc_pkg::*;
#(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] lvl_i,
  input  logic [NSRC-1:0] prev_i,
  input  logic [NSRC-1:0] cfg0_i,
  input  logic [NSRC-1:0] cfg1_i,
  input  logic [NSRC-1:0] cfg2_i,
  input  logic [NSRC-1:0] clr_rise_i,
  input  logic [NSRC-1:0] clr_fall_i,
  output logic [NSRC-1:0] rise_evt_o,
  output logic [NSRC-1:0] fall_evt_o,
  output logic [NSRC-1:0] rise_q_o,
  output logic [NSRC-1:0] fall_q_o,
  output logic [NSRC-1:0] pend_o
);
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic rise_q, fall_q;
    assign rise_evt_o[i] = lvl_i[i] & ~prev_i[i];
    assign fall_evt_o[i] = ~lvl_i[i] & prev_i[i];

    // a new event wins over a simultaneous acknowledge
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rise_q <= 1'b0;
        fall_q <= 1'b0;
      end else begin
        rise_q <= rise_evt_o[i] | (rise_q & ~clr_rise_i[i]);
        fall_q <= fall_evt_o[i] | (fall_q & ~clr_fall_i[i]);
      end
    end

    assign rise_q_o[i] = rise_q;
    assign fall_q_o[i] = fall_q;
    assign pend_o[i]   = src_pending({cfg2_i[i], cfg1_i[i], cfg0_i[i]},
                                     lvl_i[i], rise_q, fall_q);
  end
endmodule

// File: rtl/trig_intc_regs.sv
module trig_intc_regs
  import trig_intc_pkg::*;
#(
  parameter int NSRC = 32,
  parameter int AW   = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [AW-1:0]                 bus_addr,
  input  logic                          bus_we,
  input  logic [NSRC-1:0]               bus_wdata,
  input  logic [NSRC-1:0]               rise_q_i,
  input  logic [NSRC-1:0]               fall_q_i,
  input  logic [NSRC-1:0]               stat0_i,
  input  logic [NSRC-1:0]               stat1_i,
  output logic [NUM_CTL-1:0][NSRC-1:0]  ctl_o,
  output logic [NSRC-1:0]               clr_rise_o,
  output logic [NSRC-1:0]               clr_fall_o,
  output logic [NSRC-1:0]               rdata_o
);
  localparam int IW = AW - 3;

  logic [IW-1:0] widx;
  logic          walias;
  assign widx   = bus_addr[AW-1:3];
  assign walias = bus_addr[2];

  for (genvar k = 0; k < NUM_CTL; k++) begin : g_ctl
    logic hit_set, hit_clr;
    assign hit_set = bus_we && (widx == IW'(k)) && !walias;
    assign hit_clr = bus_we && (widx == IW'(k)) &&  walias;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctl_o[k] <= '0;
      else if (hit_set) ctl_o[k] <= ctl_o[k] | bus_wdata;
      else if (hit_clr) ctl_o[k] <= ctl_o[k] & ~bus_wdata;
    end
  end

  assign clr_rise_o = (bus_we && widx == IW'(IDX_RISE) && walias) ? bus_wdata : '0;
  assign clr_fall_o = (bus_we && widx == IW'(IDX_FALL) && walias) ? bus_wdata : '0;

  always_comb begin
    rdata_o = '0;
    if (widx < IW'(NUM_CTL))            rdata_o = ctl_o[widx[$clog2(NUM_CTL)-1:0]];
    else if (widx == IW'(IDX_RISE))     rdata_o = rise_q_i;
    else if (widx == IW'(IDX_FALL))     rdata_o = fall_q_i;
    else if (widx == IW'(IDX_STAT))     rdata_o = walias ? stat1_i : stat0_i;
  end
endmodule

// File: rtl/trig_intc.sv
module trig_intc
  import trig_intc_pkg::*;
#(
  parameter int NSRC = 32,
  parameter int AW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_i,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_we,
  input  logic [NSRC-1:0] bus_wdata,
  output logic [NSRC-1:0] bus_rdata,
  output logic            req0_o,
  output logic            req1_o,
  output logic            wake_o
);
  logic [NSRC-1:0] lvl, prev;
  logic [NSRC-1:0] cfg0_q, cfg1_q, cfg2_q, route_q, mask_q, wake_q;
  logic [NSRC-1:0] clr_rise, clr_fall, rise_evt, fall_evt, rise_q, fall_q, pend;
  logic [NSRC-1:0] stat0, stat1;
  logic [NUM_CTL-1:0][NSRC-1:0] ctl;

  trig_intc_sync #(.NSRC(NSRC), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw_i(irq_i), .lvl_o(lvl), .prev_o(prev)
  );

  trig_intc_detect #(.NSRC(NSRC)) u_detect (
    .clk(clk), .rst_n(rst_n), .lvl_i(lvl), .prev_i(prev),
    .cfg0_i(cfg0_q), .cfg1_i(cfg1_q), .cfg2_i(cfg2_q),
    .clr_rise_i(clr_rise), .clr_fall_i(clr_fall),
    .rise_evt_o(rise_evt), .fall_evt_o(fall_evt),
    .rise_q_o(rise_q), .fall_q_o(fall_q), .pend_o(pend)
  );

  trig_intc_regs #(.NSRC(NSRC), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .rise_q_i(rise_q), .fall_q_i(fall_q),
    .stat0_i(stat0), .stat1_i(stat1), .ctl_o(ctl),
    .clr_rise_o(clr_rise), .clr_fall_o(clr_fall), .rdata_o(bus_rdata)
  );

  assign cfg0_q  = ctl[IDX_CFG0];
  assign cfg1_q  = ctl[IDX_CFG1];
  assign cfg2_q  = ctl[IDX_CFG2];
  assign route_q = ctl[IDX_ROUTE];
  assign mask_q  = ctl[IDX_EN];
  assign wake_q  = ctl[IDX_WAKE];

  assign stat0  = pend & mask_q &  route_q;
  assign stat1  = pend & mask_q & ~route_q;
  assign req0_o = |stat0;
  assign req1_o = |stat1;
  assign wake_o = |(pend & wake_q);
endmodule

// File: rtl/trig_intc_chk.sv
module trig_intc_chk #(
  parameter int NSRC = 32,
  parameter int AW   = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [AW-1:0]   bus_addr,
  input logic            bus_we,
  input logic [NSRC-1:0] bus_wdata,
  input logic [NSRC-1:0] mask_q,
  input logic [NSRC-1:0] wake_q,
  input logic [NSRC-1:0] cfg0_q,
  input logic [NSRC-1:0] cfg1_q,
  input logic [NSRC-1:0] cfg2_q,
  input logic [NSRC-1:0] rise_evt,
  input logic [NSRC-1:0] rise_q,
  input logic            req0_o,
  input logic            req1_o,
  input logic            wake_o
);
  localparam logic [AW-1:0] EN_SET = AW'(8'h28);
  localparam logic [AW-1:0] EN_CLR = AW'(8'h2C);

  p_en_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == EN_SET) |=> ((mask_q & $past(bus_wdata)) == $past(bus_wdata)));

  p_en_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == EN_CLR) |=> ((mask_q & $past(bus_wdata)) == '0));

  p_all_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg0_q | cfg1_q | cfg2_q) == '0) |-> (!req0_o && !req1_o && !wake_o));

  p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_evt != '0) |=> ((rise_q & $past(rise_evt)) == $past(rise_evt)));

  p_no_en_no_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> (!req0_o && !req1_o));

  p_no_wake_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_q == '0) |-> !wake_o);
endmodule

bind trig_intc trig_intc_chk #(.NSRC(NSRC), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .mask_q(mask_q), .wake_q(wake_q),
  .cfg0_q(cfg0_q), .cfg1_q(cfg1_q), .cfg2_q(cfg2_q),
  .rise_evt(rise_evt), .rise_q(rise_q),
  .req0_o(req0_o), .req1_o(req1_o), .wake_o(wake_o)
);

// File: tb/trig_intc_tb.sv
module trig_intc_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_i = '0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        req0_o, req1_o, wake_o;
  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  trig_intc u_dut (
    .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .req0_o(req0_o), .req1_o(req1_o), .wake_o(wake_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic outs(input string tag, input logic r0, input logic r1, input logic w);
    check(tag, {29'd0, wake_o, req1_o, req0_o}, {29'd0, w, r1, r0});
  endtask

  task automatic wipe();
    irq_i = '0;
    for (int k = 0; k < 7; k++) wr(8'(k * 8 + 4), 32'hFFFF_FFFF);
    step(3);
    wr(8'h3C, 32'hFFFF_FFFF);
    wr(8'h44, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int k = 0; k < 20; k++) begin
      rd(8'(k * 4), d);
      check("R1 reset word", d, 32'h0);
    end
    outs("R1 reset outputs", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_setclr();
    logic [31:0] d;
    for (int k = 0; k < 7; k++) begin
      wr(8'(k * 8), 32'hF0F0_0000);
      wr(8'(k * 8), 32'h0000_000F);
      rd(8'(k * 8), d);
      check("R2 set alias", d, 32'hF0F0_000F);
      wr(8'(k * 8 + 4), 32'hF000_0003);
      rd(8'(k * 8 + 4), d);
      check("R2 clear alias", d, 32'h00F0_000C);
    end
    wipe();
  endtask

  task automatic t_level_high();
    logic [31:0] d;
    wr(8'h10, 32'h8); wr(8'h00, 32'h8);   // code 101
    wr(8'h18, 32'h8); wr(8'h28, 32'h8);   // route to 0, enable
    irq_i[3] = 1'b1;
    step(1); rd(8'h48, d); check("R4 high level one edge", d, 32'h0);
    step(1); rd(8'h48, d); check("R4 high level two edges", d, 32'h8);
    outs("R6 route to req0", 1'b1, 1'b0, 1'b0);
    rd(8'h4C, d); check("R6 status1 empty", d, 32'h0);
    wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h20, d); check("R9 source select readback", d, 32'hFFFF_FFFF);
    rd(8'h48, d); check("R9 source select no effect", d, 32'h8);
    wr(8'h24, 32'hFFFF_FFFF);
    rd(8'h48, d); check("R9 source select clear no effect", d, 32'h8);
    wr(8'h08, 32'h8);                     // code 111: disabled
    rd(8'h48, d); check("R3 code 111 disabled", d, 32'h0);
    wr(8'h0C, 32'h8); wr(8'h14, 32'h8);   // code 001 with no capture... then 000
    wr(8'h04, 32'h8);
    rd(8'h48, d); check("R3 code 000 disabled", d, 32'h0);
    irq_i[3] = 1'b0;
    wipe();
  endtask

  task automatic t_level_low();
    logic [31:0] d;
    wr(8'h10, 32'h20); wr(8'h08, 32'h20); // code 110
    wr(8'h28, 32'h20);                    // route bit 0 -> req1
    rd(8'h4C, d); check("R3 low level input low", d, 32'h20);
    outs("R6 route to req1", 1'b0, 1'b1, 1'b0);
    irq_i[5] = 1'b1;
    step(1); rd(8'h4C, d); check("R4 low level one edge", d, 32'h20);
    step(1); rd(8'h4C, d); check("R4 low level two edges", d, 32'h0);
    outs("R4 low level released", 1'b0, 1'b0, 1'b0);
    wipe();
  endtask

  task automatic t_rise();
    logic [31:0] d;
    wr(8'h00, 32'h100); wr(8'h18, 32'h100); // code 001, route 0, not enabled
    irq_i[8] = 1'b1;
    step(2); rd(8'h38, d); check("R5 capture not yet", d & 32'h100, 32'h0);
    step(1); rd(8'h38, d); check("R5 capture third edge", d & 32'h100, 32'h100);
    irq_i[8] = 1'b0;
    step(4);
    rd(8'h48, d); check("R7 disabled source hidden", d, 32'h0);
    outs("R7 disabled source no request", 1'b0, 1'b0, 1'b0);
    wr(8'h28, 32'h100);
    rd(8'h48, d); check("R5 captured while disabled", d, 32'h100);
    outs("R6 rise to req0", 1'b1, 1'b0, 1'b0);
    wr(8'h44, 32'h100);
    rd(8'h48, d); check("R5 fall clear leaves rise", d, 32'h100);
    wr(8'h3C, 32'h100);
    rd(8'h38, d); check("R5 rise cleared", d & 32'h100, 32'h0);
    outs("R5 request gone after clear", 1'b0, 1'b0, 1'b0);
    wipe();
  endtask

  task automatic t_fall_wake();
    logic [31:0] d;
    wr(8'h08, 32'h200);                   // code 010, route 1 -> req1
    irq_i[9] = 1'b1;
    step(4);
    wr(8'h3C, 32'h200);
    wr(8'h28, 32'h200);
    outs("R3 falling mode ignores rise", 1'b0, 1'b0, 1'b0);
    irq_i[9] = 1'b0;
    step(2); outs("R5 fall not yet", 1'b0, 1'b0, 1'b0);
    step(1); outs("R5 fall third edge", 1'b0, 1'b1, 1'b0);
    rd(8'h4C, d); check("R6 fall status1", d, 32'h200);
    wr(8'h2C, 32'h200);
    outs("R7 disabled fall", 1'b0, 1'b0, 1'b0);
    wr(8'h30, 32'h200);
    outs("R8 wake without enable", 1'b0, 1'b0, 1'b1);
    wr(8'h34, 32'h200);
    outs("R8 wake cleared", 1'b0, 1'b0, 1'b0);
    wr(8'h30, 32'h200);
    wr(8'h44, 32'h200);
    outs("R8 no wake after ack", 1'b0, 1'b0, 1'b0);
    rd(8'h40, d); check("R5 fall capture cleared", d & 32'h200, 32'h0);
    wipe();
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_setclr();
    t_level_high();
    t_level_low();
    t_rise();
    t_fall_wake();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule